// File: doc/BRIEF.md
# Wait-Balancing Flash Transaction Dispatcher

This block sits in front of a flash channel controller and picks the single transaction that goes out next. Two candidates compete: the user read waiting in the read slot and the user write waiting in the write slot. Each candidate's waiting time (current time minus its arrival stamp) is weighed against a per-type service cost, so a long-waiting write can overtake a read. A read's cost is much smaller than a write's, so a read needs far less waiting to win. The comparison is done by cross-multiplication, with no division.

When the write wins and garbage-collection work is pending, the block first issues a bounded burst of garbage-collection transactions. A budget input sets the size of the burst, GC reads go before GC writes, and the burst ends early if the GC queues run dry. The user write follows directly after the burst. Once a burst has started, the write is committed and no user read can cut in. Every transfer uses a valid/ready handshake on one output port. A per-source pop strobe tells the feeding slot or queue that its head was taken.

Top module: `wait_balance_dispatch`

## Requirements
- R1: While reset is asserted, `out_valid_o` is low and no pop strobe is raised.
- R2: With both user slots occupied and no burst in progress, the read is offered when `waitR*WR_COST >= waitW*RD_COST`; otherwise the write path is taken. A tie goes to the read.
- R3: With only one user slot occupied, that slot is served without comparison: the read directly, or the write through the write path.
- R4: When the write path is taken with a budget B > 0 and a non-empty GC queue, at most B GC transactions are dispatched before the write. The budget is captured when the first GC transaction is accepted.
- R5: Within a burst, the GC read queue head is always offered ahead of the GC write queue head.
- R6: A burst ends, and the user write is offered, as soon as the budget is used up or both GC queues are empty. A burst is left only by dispatching the user write.
- R7: When the write path is taken with a budget of zero, or with both GC queues empty, the user write is offered directly.
- R8: A transfer, and its pop strobe, happens only in a cycle where `out_valid_o` and `out_ready_i` are both high. At most one pop strobe is high per cycle, and an offered transaction stays in its slot until it is accepted.
- R9: While a burst is in progress, no user read is offered, however long it has waited.
- R10: Waiting time is computed modulo 2^TIME_W, so a stamp taken before the time counter wrapped gives the correct elapsed time.
- R11: `out_kind_o` encodes the source as 0 = user read, 1 = user write, 2 = GC read, 3 = GC write. `out_tag_o` carries the tag of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TIME_W | Free-running current time |
| rd_valid_i | input | 1 | Read slot occupied |
| rd_stamp_i | input | TIME_W | Arrival time of the read |
| rd_tag_i | input | TAG_W | Tag of the read |
| wr_valid_i | input | 1 | Write slot occupied |
| wr_stamp_i | input | TIME_W | Arrival time of the write |
| wr_tag_i | input | TAG_W | Tag of the write |
| gcr_valid_i | input | 1 | GC read queue not empty |
| gcr_tag_i | input | TAG_W | Tag at GC read queue head |
| gcw_valid_i | input | 1 | GC write queue not empty |
| gcw_tag_i | input | TAG_W | Tag at GC write queue head |
| gc_budget_i | input | BUD_W | Maximum GC transactions ahead of a winning write |
| out_ready_i | input | 1 | Channel controller accepts a transaction |
| out_valid_o | output | 1 | A transaction is offered |
| out_kind_o | output | 2 | Source of the offered transaction |
| out_tag_o | output | TAG_W | Tag of the offered transaction |
| rd_pop_o | output | 1 | Read slot consumed |
| wr_pop_o | output | 1 | Write slot consumed |
| gcr_pop_o | output | 1 | GC read head consumed |
| gcw_pop_o | output | 1 | GC write head consumed |

## Verification
The offer (valid, kind, tag) and the pop strobes are combinational from the slot and queue inputs and the burst state, so they are due in the same cycle the inputs are applied. The bench drives on the falling edge and samples one time unit later, well before the next rising edge. A burst starts, shrinks or ends at the rising edge where a transfer completes, so its effect on the offer shows up one cycle later. The bench model updates its own burst state at that same point, so every next-cycle prediction uses the state the design holds after the edge.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
  typedef enum logic [1:0] {
    K_URD = 2'd0,
    K_UWR = 2'd1,
    K_GRD = 2'd2,
    K_GWR = 2'd3
  } kind_e;
endpackage

// File: rtl/wbd_wait_cmp.sv
module wbd_wait_cmp #(
  parameter int TIME_W  = 8,
  parameter int COST_W  = 8,
  parameter int RD_COST = 1,
  parameter int WR_COST = 16
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] rd_stamp_i,
  input  logic [TIME_W-1:0] wr_stamp_i,
  output logic              rd_first_o
);
  localparam int PW = TIME_W + COST_W;
  localparam logic [COST_W-1:0] RC = COST_W'(RD_COST);
  localparam logic [COST_W-1:0] WC = COST_W'(WR_COST);

  function automatic logic [TIME_W-1:0] elapsed(input logic [TIME_W-1:0] t,
                                                input logic [TIME_W-1:0] s);
    return t - s;
  endfunction

  function automatic logic [PW-1:0] weigh(input logic [TIME_W-1:0] w,
                                          input logic [COST_W-1:0] c);
    return PW'(w) * PW'(c);
  endfunction

  logic [TIME_W-1:0] stamp [2];
  logic [PW-1:0]     score [2];
  assign stamp[0] = rd_stamp_i;
  assign stamp[1] = wr_stamp_i;

  // Each side is scaled by the other side's cost: waitR*tW versus waitW*tR.
  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam logic [COST_W-1:0] CROSS = (s == 0) ? WC : RC;
    assign score[s] = weigh(elapsed(now_i, stamp[s]), CROSS);
  end

  assign rd_first_o = score[0] >= score[1];
endmodule

// File: rtl/wbd_gc_burst.sv
module wbd_gc_burst #(
  parameter int BUD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BUD_W-1:0] budget_i,
  input  logic             gc_take_i,
  input  logic             wr_take_i,
  output logic             active_o,
  output logic             left_nz_o
);
  logic             active_q;
  logic [BUD_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (wr_take_i) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      left_q   <= budget_i - 1'b1;
    end else if (gc_take_i && active_q && left_q != '0) begin
      left_q   <= left_q - 1'b1;
    end
  end

  assign active_o  = active_q;
  assign left_nz_o = left_q != '0;

  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_q && budget_i != '0);
  assert_left_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && gc_take_i) |-> left_q != '0);
  assert_no_budget_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !wr_take_i) |=> left_q <= $past(left_q));
endmodule

// File: rtl/wbd_pick.sv
module wbd_pick
  import wbd_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             en_i,
  input  logic             active_i,
  input  logic             left_nz_i,
  input  logic             budget_nz_i,
  input  logic             rd_first_i,
  input  logic             rd_valid_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             wr_valid_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             gcr_valid_i,
  input  logic [TAG_W-1:0] gcr_tag_i,
  input  logic             gcw_valid_i,
  input  logic [TAG_W-1:0] gcw_tag_i,
  input  logic             ready_i,
  output logic             valid_o,
  output kind_e            kind_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [3:0]       pop_o,
  output logic             start_o,
  output logic             gc_take_o,
  output logic             wr_take_o
);
  logic             gc_any;
  kind_e            gc_kind;
  logic [TAG_W-1:0] gc_tag;
  logic             wr_path;
  logic             offer_gc;
  logic             fire;

  assign gc_any  = gcr_valid_i | gcw_valid_i;
  assign gc_kind = gcr_valid_i ? K_GRD : K_GWR;
  assign gc_tag  = gcr_valid_i ? gcr_tag_i : gcw_tag_i;
  assign wr_path = wr_valid_i && !(rd_valid_i && rd_first_i);

  always_comb begin
    valid_o  = 1'b0;
    kind_o   = K_URD;
    tag_o    = '0;
    offer_gc = 1'b0;
    if (en_i) begin
      if (active_i) begin
        if (left_nz_i && gc_any) begin
          offer_gc = 1'b1;
        end else if (wr_valid_i) begin
          valid_o = 1'b1;
          kind_o  = K_UWR;
          tag_o   = wr_tag_i;
        end
      end else if (rd_valid_i && !wr_path) begin
        valid_o = 1'b1;
        kind_o  = K_URD;
        tag_o   = rd_tag_i;
      end else if (wr_path) begin
        if (budget_nz_i && gc_any) begin
          offer_gc = 1'b1;
        end else begin
          valid_o = 1'b1;
          kind_o  = K_UWR;
          tag_o   = wr_tag_i;
        end
      end
      if (offer_gc) begin
        valid_o = 1'b1;
        kind_o  = gc_kind;
        tag_o   = gc_tag;
      end
    end
  end

  assign fire = valid_o & ready_i;

  for (genvar k = 0; k < 4; k++) begin : g_pop
    assign pop_o[k] = fire && (kind_o == kind_e'(k));
  end

  assign gc_take_o = pop_o[K_GRD] | pop_o[K_GWR];
  assign start_o   = gc_take_o & ~active_i;
  assign wr_take_o = pop_o[K_UWR];
endmodule

// File: rtl/wait_balance_dispatch.sv
module wait_balance_dispatch
  import wbd_pkg::*;
#(
  parameter int TIME_W  = 8,
  parameter int TAG_W   = 8,
  parameter int BUD_W   = 4,
  parameter int COST_W  = 8,
  parameter int RD_COST = 1,
  parameter int WR_COST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              rd_valid_i,
  input  logic [TIME_W-1:0] rd_stamp_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              wr_valid_i,
  input  logic [TIME_W-1:0] wr_stamp_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              gcr_valid_i,
  input  logic [TAG_W-1:0]  gcr_tag_i,
  input  logic              gcw_valid_i,
  input  logic [TAG_W-1:0]  gcw_tag_i,
  input  logic [BUD_W-1:0]  gc_budget_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [1:0]        out_kind_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              rd_pop_o,
  output logic              wr_pop_o,
  output logic              gcr_pop_o,
  output logic              gcw_pop_o
);
  // Named internal events, shared by the sub-blocks and the assertions.
  logic       rd_first;
  logic       burst_active;
  logic       burst_left_nz;
  logic       burst_start;
  logic       gc_take;
  logic       wr_take;
  logic [3:0] pop;
  kind_e      kind;

  wbd_wait_cmp #(
    .TIME_W(TIME_W), .COST_W(COST_W), .RD_COST(RD_COST), .WR_COST(WR_COST)
  ) u_cmp (
    .now_i(now_i), .rd_stamp_i(rd_stamp_i), .wr_stamp_i(wr_stamp_i),
    .rd_first_o(rd_first)
  );

  wbd_gc_burst #(.BUD_W(BUD_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start_i(burst_start), .budget_i(gc_budget_i),
    .gc_take_i(gc_take), .wr_take_i(wr_take),
    .active_o(burst_active), .left_nz_o(burst_left_nz)
  );

  wbd_pick #(.TAG_W(TAG_W)) u_pick (
    .en_i(rst_n), .active_i(burst_active), .left_nz_i(burst_left_nz),
    .budget_nz_i(gc_budget_i != '0), .rd_first_i(rd_first),
    .rd_valid_i(rd_valid_i), .rd_tag_i(rd_tag_i),
    .wr_valid_i(wr_valid_i), .wr_tag_i(wr_tag_i),
    .gcr_valid_i(gcr_valid_i), .gcr_tag_i(gcr_tag_i),
    .gcw_valid_i(gcw_valid_i), .gcw_tag_i(gcw_tag_i),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .kind_o(kind),
    .tag_o(out_tag_o), .pop_o(pop), .start_o(burst_start),
    .gc_take_o(gc_take), .wr_take_o(wr_take)
  );

  assign out_kind_o = kind;
  assign rd_pop_o   = pop[K_URD];
  assign wr_pop_o   = pop[K_UWR];
  assign gcr_pop_o  = pop[K_GRD];
  assign gcw_pop_o  = pop[K_GWR];

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !out_valid_o && pop == 4'b0);
  assert_one_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
  assert_pop_needs_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != 4'b0) |-> out_valid_o && out_ready_i);
  assert_read_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && kind == K_URD) |-> rd_valid_i);
  assert_gc_read_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && kind == K_GWR) |-> !gcr_valid_i);
  assert_commit_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && out_valid_o) |-> kind != K_URD);
  assert_exit_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active) |-> $past(wr_pop_o));
endmodule

// File: tb/wait_balance_dispatch_tb_top.sv
module wait_balance_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIME_W = 8, TAG_W = 8, BUD_W = 4, COST_W = 8;
  localparam int RD_COST = 1, WR_COST = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TIME_W-1:0] now_i, rd_stamp_i, wr_stamp_i;
  logic [TAG_W-1:0] rd_tag_i, wr_tag_i, gcr_tag_i, gcw_tag_i, out_tag_o;
  logic rd_valid_i, wr_valid_i, gcr_valid_i, gcw_valid_i, out_ready_i;
  logic [BUD_W-1:0] gc_budget_i;
  logic out_valid_o, rd_pop_o, wr_pop_o, gcr_pop_o, gcw_pop_o;
  logic [1:0] out_kind_o;

  wait_balance_dispatch #(
    .TIME_W(TIME_W), .TAG_W(TAG_W), .BUD_W(BUD_W), .COST_W(COST_W),
    .RD_COST(RD_COST), .WR_COST(WR_COST)
  ) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0;
  // bench environment and model state
  bit rv, wv, rdy;
  int rs, ws, rt, wt, ngr, ngw, bud, tnow;
  bit m_burst;
  int m_left;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int elapsed(input int t, input int s);
    return (t - s) & ((1 << TIME_W) - 1);
  endfunction

  // expected offer: kind -1 means nothing offered
  function automatic int predict_kind();
    bit gc_any = (ngr > 0) || (ngw > 0);
    int gck = (ngr > 0) ? 2 : 3;
    bit read_ok;
    if (m_burst) begin
      if (m_left > 0 && gc_any) return gck;
      return wv ? 1 : -1;
    end
    read_ok = rv && (!wv || elapsed(tnow, rs) * WR_COST >= elapsed(tnow, ws) * RD_COST);
    if (read_ok) return 0;
    if (!wv) return -1;
    if (bud > 0 && gc_any) return gck;
    return 1;
  endfunction

  function automatic int tag_for(input int k);
    case (k)
      0: return rt;
      1: return wt;
      2: return 8'h80 + ngr;
      default: return 8'hC0 + ngw;
    endcase
  endfunction

  task automatic drive();
    now_i = TIME_W'(tnow);
    rd_valid_i = rv; rd_stamp_i = TIME_W'(rs); rd_tag_i = TAG_W'(rt);
    wr_valid_i = wv; wr_stamp_i = TIME_W'(ws); wr_tag_i = TAG_W'(wt);
    gcr_valid_i = ngr > 0; gcr_tag_i = TAG_W'(8'h80 + ngr);
    gcw_valid_i = ngw > 0; gcw_tag_i = TAG_W'(8'hC0 + ngw);
    gc_budget_i = BUD_W'(bud); out_ready_i = rdy;
  endtask

  task automatic step(input string req);
    int ek, pops_exp, pops_act;
    @(negedge clk);
    drive();
    #1;
    ek = predict_kind();
    check(out_valid_o == (ek >= 0), req, out_valid_o, ek >= 0);
    if (ek >= 0) begin
      check(int'(out_kind_o) == ek, {req, " R11 kind"}, out_kind_o, ek);
      check(int'(out_tag_o) == tag_for(ek), {req, " R11 tag"}, out_tag_o, tag_for(ek));
    end
    pops_exp = (ek >= 0 && rdy) ? (1 << ek) : 0;
    pops_act = {gcw_pop_o, gcr_pop_o, wr_pop_o, rd_pop_o};
    check(pops_act == pops_exp, {req, " R8 pops"}, pops_act, pops_exp);
    if (ek >= 0 && rdy) begin
      case (ek)
        0: rv = 0;
        1: begin wv = 0; m_burst = 0; m_left = 0; end
        default: begin
          if (!m_burst) begin m_burst = 1; m_left = bud - 1; end
          else m_left--;
          if (ek == 2) ngr--; else ngw--;
        end
      endcase
    end
    tnow++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tnow = 0; rv = 1; rs = 0; rt = 8'h11; wv = 1; ws = 0; wt = 8'h22;
    ngr = 1; ngw = 1; bud = 2; rdy = 1; m_burst = 0; m_left = 0;
    drive();
    // R1: reset holds the output quiet
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(!out_valid_o, "R1 valid", out_valid_o, 0);
      check({gcw_pop_o, gcr_pop_o, wr_pop_o, rd_pop_o} == 4'b0, "R1 pops",
            {gcw_pop_o, gcr_pop_o, wr_pop_o, rd_pop_o}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    ngr = 0; ngw = 0; bud = 0; rv = 0; wv = 0;
    // R3: lone read
    rv = 1; rs = tnow - 3; rt = 8'h31; step("R3 lone read");
    // R2: tie, read wait 1 vs write wait 16 -> read
    rv = 1; rs = tnow - 1; rt = 8'h41; wv = 1; ws = tnow - 16; wt = 8'h42;
    step("R2 tie to read");
    // R3/R7: lone write with zero budget
    step("R7 write direct");
    // R2: write wins by one unit
    rv = 1; rs = tnow - 1; rt = 8'h51; wv = 1; ws = tnow - 17; wt = 8'h52;
    step("R2 write wins");
    step("R3 read after write");
    // R4/R5/R9/R8: burst of 3 with GC reads first, read aging meanwhile
    ngr = 2; ngw = 3; bud = 3;
    rv = 1; rs = tnow; rt = 8'h61; wv = 1; ws = tnow - 5; wt = 8'h62;
    step("R4 burst first");
    rs = tnow - 200; bud = 0;
    step("R9 burst commit");
    rdy = 0; step("R8 stall in burst");
    rdy = 1; step("R5 gc write after reads");
    step("R4 budget spent write");
    step("R2 read after burst");
    // R6: queues drain before budget
    ngr = 1; ngw = 0; bud = 4; wv = 1; ws = tnow - 2; wt = 8'h72;
    step("R6 single gc");
    step("R6 write after drain");
    // R7: budget present, queues empty
    bud = 3; wv = 1; ws = tnow; wt = 8'h73; step("R7 empty queues");
    ngw = 0; ngr = 0;
    // R10: read stamp ahead of now by 10 wraps to wait 246
    rv = 1; rs = tnow + 10; rt = 8'h81; wv = 1; ws = tnow - 200; wt = 8'h82;
    step("R10 wrap");
    step("R7 write after wrap");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (!rv && $urandom % 3 == 0) begin rv = 1; rs = tnow - int'($urandom % 40); rt = $urandom % 256; end
      if (!wv && $urandom % 3 == 0) begin wv = 1; ws = tnow - int'($urandom % 60); wt = $urandom % 256; end
      if (ngr < 5 && $urandom % 6 == 0) ngr++;
      if (ngw < 5 && $urandom % 6 == 0) ngw++;
      bud = $urandom % 5;
      rdy = ($urandom % 4) != 0;
      step("R2 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule